// File: doc/BRIEF.md
# Masked Level-Interrupt Combiner

This block gathers a set of level-sensitive interrupt requests and folds them onto two processor request lines: a fast line, which the processor serves ahead of everything else, and a normal line. Every source has one enable bit. A source reaches its line only while that bit is 1. Nothing is captured inside the block. Each line is a purely combinational OR of its enabled sources, so it follows the live source levels. When several sources on one line are active together, software decides which to serve first.

Software uses a small word-addressed register port. It can read the live source levels and the enabled subset of them. It can also read the enable word and change it in three ways: load the whole word, set selected bits, or clear selected bits. Reset clears the enable word, so all sources start disabled. The source count and the size of the fast group are parameters. By default there are 28 sources, and the lowest four of them feed the fast line.

Top module: `intc_unlatched_top`

## Requirements
- R1: `fast_irq` is high exactly when at least one of sources 0 to NUM_FAST-1 (0..3 by default) is high and its enable bit is 1.
- R2: `norm_irq` is high exactly when at least one of sources NUM_FAST to NUM_SRC-1 (4..27 by default) is high and its enable bit is 1. Sources of one group never affect the other line.
- R3: Nothing is stored on the request path. In the same cycle that an enabled source drops, its line drops too, unless another enabled source in the same group is still high.
- R4: After reset the enable word reads 0, and both lines stay low whatever the sources are doing.
- R5: A write to byte offset 0x8 loads the enable word from `reg_wdata[NUM_SRC-1:0]`. The new value appears after that clock edge.
- R6: A write to offset 0xC sets the enable bits where the write data is 1. All other bits keep their value.
- R7: A write to offset 0x10 clears the enable bits where the write data is 1. All other bits keep their value.
- R8: A read at offset 0x0 returns the live source levels, with source n at bit n.
- R9: A read at offset 0x4 returns the sources ANDed with the enable word, with source n at bit n.
- R10: Bits 31:NUM_SRC (31:28 by default) read as 0 at every offset. Reads at unmapped offsets return 0. Writes to offsets 0x0, 0x4 or unmapped offsets leave the enable word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the enable register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 28 | Level-sensitive interrupt sources |
| reg_addr | input | 5 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fast_irq | output | 1 | Fast interrupt request line |
| norm_irq | output | 1 | Normal interrupt request line |

## Verification
The bench builds the block with its defaults: 28 sources, a fast group of four, a 32-bit data word and a 5-bit offset. This width leaves bits 31:28 unused, so the bench can check that they read as zero and that writes to them are ignored. The random mix of enable words and source patterns exercises both sides of the group boundary between bits 3 and 4, as well as the top source, bit 27. Directed steps cover the all-sources-high case right after reset and a source dropping while the bench watches its line in the same cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned OFS_RAW  = 0;
   localparam int unsigned OFS_MSKD = 4;
   localparam int unsigned OFS_MASK = 8;
   localparam int unsigned OFS_SET  = 12;
   localparam int unsigned OFS_CLR  = 16;

   typedef enum logic [1:0] {
      MOP_NONE = 2'd0,
      MOP_LOAD = 2'd1,
      MOP_SET  = 2'd2,
      MOP_CLR  = 2'd3
   } mask_op_e;

endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  mask_op_e           op,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask_q
);

   logic [NUM_SRC-1:0] mask_d;

   always_comb begin
      unique case (op)
         MOP_LOAD: mask_d = wbits;
         MOP_SET:  mask_d = mask_q | wbits;
         MOP_CLR:  mask_d = mask_q & ~wbits;
         default:  mask_d = mask_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   // R4
   mask_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_q == '0));

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == MOP_LOAD) |=> (mask_q == $past(wbits)));

   // R6
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == MOP_SET) |=> (mask_q == ($past(mask_q) | $past(wbits))));

   // R7
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == MOP_CLR) |=> (mask_q == ($past(mask_q) & ~$past(wbits))));

   // R10
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == MOP_NONE) |=> $stable(mask_q));

endmodule

// File: rtl/intc_line_gate.sv
module intc_line_gate #(
   parameter int unsigned NUM_SRC  = 28,
   parameter int unsigned NUM_FAST = 4
) (
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] masked,
   output logic               fast_o,
   output logic               norm_o
);

   localparam int unsigned NUM_NORM = NUM_SRC - NUM_FAST;

   logic [NUM_FAST-1:0] fast_chain;
   logic [NUM_NORM-1:0] norm_chain;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign masked[i] = src[i] & mask[i];
   end

   for (genvar f = 0; f < NUM_FAST; f++) begin : g_fast
      if (f == 0) begin : g_first
         assign fast_chain[f] = masked[f];
      end else begin : g_next
         assign fast_chain[f] = fast_chain[f-1] | masked[f];
      end
   end

   for (genvar n = 0; n < NUM_NORM; n++) begin : g_norm
      if (n == 0) begin : g_first
         assign norm_chain[n] = masked[NUM_FAST+n];
      end else begin : g_next
         assign norm_chain[n] = norm_chain[n-1] | masked[NUM_FAST+n];
      end
   end

   assign fast_o = fast_chain[NUM_FAST-1];
   assign norm_o = norm_chain[NUM_NORM-1];

endmodule

// File: rtl/intc_bus_port.sv
module intc_bus_port
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 28,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] raw,
   input  logic [NUM_SRC-1:0] masked,
   input  logic [NUM_SRC-1:0] mask,
   output mask_op_e           op,
   output logic [NUM_SRC-1:0] wbits,
   output logic [DATA_W-1:0]  rdata
);

   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(OFS_MSKD);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

   assign wbits = wdata[NUM_SRC-1:0];

   always_comb begin
      op = MOP_NONE;
      if (wr) begin
         if (addr == A_MASK)     op = MOP_LOAD;
         else if (addr == A_SET) op = MOP_SET;
         else if (addr == A_CLR) op = MOP_CLR;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_RAW)       rdata[NUM_SRC-1:0] = raw;
      else if (addr == A_MSKD) rdata[NUM_SRC-1:0] = masked;
      else if (addr == A_MASK) rdata[NUM_SRC-1:0] = mask;
   end

endmodule

// File: rtl/intc_unlatched_top.sv
module intc_unlatched_top
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 28,
   parameter int unsigned NUM_FAST = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               fast_irq,
   output logic               norm_irq
);

   if (NUM_FAST < 1 || NUM_FAST >= NUM_SRC) begin : g_bad_split
      $error("fast group must be non-empty and leave at least one normal source");
   end
   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("source count exceeds data width");
   end
   if ((1 << ADDR_W) <= OFS_CLR) begin : g_bad_addr
      $error("offset width too small for the register map");
   end

   mask_op_e           op;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] masked;

   intc_bus_port #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_port (
      .addr   (reg_addr),
      .wr     (reg_wr),
      .wdata  (reg_wdata),
      .raw    (src_lvl),
      .masked (masked),
      .mask   (mask_q),
      .op     (op),
      .wbits  (wbits),
      .rdata  (reg_rdata)
   );

   intc_mask_reg #(
      .NUM_SRC (NUM_SRC)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .wbits  (wbits),
      .mask_q (mask_q)
   );

   intc_line_gate #(
      .NUM_SRC  (NUM_SRC),
      .NUM_FAST (NUM_FAST)
   ) u_gate (
      .src    (src_lvl),
      .mask   (mask_q),
      .masked (masked),
      .fast_o (fast_irq),
      .norm_o (norm_irq)
   );

endmodule

// File: tb/tb_intc_unlatched_top.sv
module tb_intc_unlatched_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [27:0] src_lvl;
   logic [4:0]  reg_addr;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        fast_irq;
   logic        norm_irq;

   int total = 0;
   int bad   = 0;
   logic [27:0] mdl_mask;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   intc_unlatched_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_lvl   (src_lvl),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .fast_irq  (fast_irq),
      .norm_irq  (norm_irq)
   );

   function automatic logic exp_fast(logic [27:0] s, logic [27:0] m);
      return |(s[3:0] & m[3:0]);
   endfunction

   function automatic logic exp_norm(logic [27:0] s, logic [27:0] m);
      return |(s[27:4] & m[27:4]);
   endfunction

   function automatic logic [31:0] exp_read(logic [4:0] a, logic [27:0] s, logic [27:0] m);
      case (a)
         5'h00:   return {4'h0, s};
         5'h04:   return {4'h0, s & m};
         5'h08:   return {4'h0, m};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      case (a)
         5'h08: mdl_mask = d[27:0];
         5'h0C: mdl_mask = mdl_mask | d[27:0];
         5'h10: mdl_mask = mdl_mask & ~d[27:0];
         default: ;
      endcase
   endtask

   task automatic rd_chk(string tag, logic [4:0] a);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp_read(a, src_lvl, mdl_mask));
   endtask

   task automatic lines_chk(string tag);
      #1;
      chk({tag, " R1 fast"}, {31'h0, fast_irq}, {31'h0, exp_fast(src_lvl, mdl_mask)});
      chk({tag, " R2 norm"}, {31'h0, norm_irq}, {31'h0, exp_norm(src_lvl, mdl_mask)});
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [4:0] offs [6];
      void'($urandom(32'd20240611));
      offs[0] = 5'h00; offs[1] = 5'h04; offs[2] = 5'h08;
      offs[3] = 5'h0C; offs[4] = 5'h10; offs[5] = 5'h14;
      rst_n = 1'b0; src_lvl = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
      mdl_mask = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: everything disabled after reset, even with all sources high
      src_lvl = '1;
      #1;
      chk("R4 fast after reset", {31'h0, fast_irq}, 32'h0);
      chk("R4 norm after reset", {31'h0, norm_irq}, 32'h0);
      rd_chk("R4 mask reads zero", 5'h08);
      rd_chk("R8 raw all high", 5'h00);

      // R6 set one fast bit, R1 fast line
      wr_reg(5'h0C, 32'h0000_0001);
      src_lvl = 28'h000_0001; lines_chk("R6 set bit0");
      // R2 normal source alone keeps fast low
      wr_reg(5'h0C, 32'h0000_0400);
      src_lvl = 28'h000_0400; lines_chk("R2 bit10");
      rd_chk("R6 mask after sets", 5'h08);
      // R3 immediate drop without latching
      src_lvl = 28'h000_0000;
      #1;
      chk("R3 norm drops same cycle", {31'h0, norm_irq}, 32'h0);
      // group boundary bits 3,4 and top bit 27
      wr_reg(5'h0C, 32'h0800_0018);
      src_lvl = 28'h000_0008; lines_chk("R1 bit3");
      src_lvl = 28'h000_0010; lines_chk("R2 bit4");
      src_lvl = 28'h800_0000; lines_chk("R2 bit27");
      // R7 clear
      wr_reg(5'h10, 32'h0800_0001);
      rd_chk("R7 mask after clear", 5'h08);
      src_lvl = 28'h800_0001; lines_chk("R7 cleared sources");
      // R5 load with upper bits, R10 upper reads zero
      wr_reg(5'h08, 32'hFFFF_FFFF);
      rd_chk("R5 R10 load all ones", 5'h08);
      // R10 writes to read-only and unmapped offsets
      wr_reg(5'h00, 32'h0000_0000);
      wr_reg(5'h04, 32'h0000_0000);
      wr_reg(5'h14, 32'h0000_0000);
      rd_chk("R10 mask unchanged", 5'h08);
      src_lvl = 28'hABC_DEF1;
      rd_chk("R10 unmapped read", 5'h14);
      rd_chk("R9 masked status", 5'h04);

      // constrained random phase
      for (int it = 0; it < 400; it++) begin
         logic [31:0] d;
         int unsigned k;
         k = $urandom_range(0, 5);
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d = d & 32'hF000_000F;
         wr_reg(offs[k], d);
         src_lvl = 28'($urandom);
         if ($urandom_range(0, 3) == 0) src_lvl = src_lvl & 28'h800_0018;
         lines_chk("R1 R2 random");
         rd_chk("R8 random raw", 5'h00);
         rd_chk("R9 random masked", 5'h04);
         rd_chk("R5 R6 R7 random mask", 5'h08);
      end

      summary();
   end

endmodule